// File: doc/BRIEF.md
# Cartridge Bank Mapper with Interval Interrupt

This block holds the bank selection logic of a game cartridge on an 8-bit CPU bus. It turns CPU reads in the upper 40K of the address space into a 17-bit address for a 128K ROM built from sixteen 8K banks. Four of the five 8K windows from 6000h up map to fixed banks. The C000h-DFFFh window follows a 4-bit page register, whose bits are reordered before they form the bank number.

Two write-only registers sit in the 4000h-5FFFh region. They use a sparse decode, so each has many mirror addresses. The first is the page register. The second is a one-bit timer switch. When the switch is on, a counter clocked by the bus clock runs. After 4096 bus cycles it pulls an active-low interrupt line. The line stays low until software turns the timer off. Turning the timer off also clears the count. Software typically starts the timer at the top of the frame so that the interrupt marks a split point further down the screen.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write reaches a register only when address bits 15..13 are 010, bit 6 is 0 and bit 5 is 1. Every other address bit, except bit 8, has no effect on the decode (for example 5EBFh is a valid page address).
- R2: Address bit 8 of a decoded write picks the target. A value of 0 selects the page register (canonical 4020h) and a value of 1 selects the timer switch (canonical 4120h). A write to the page register never starts the timer.
- R3: The page register stores data bits 3..0. Data bits 7..4 are discarded.
- R4: Reads in 6000h-7FFFh, 8000h-9FFFh, A000h-BFFFh and E000h-FFFFh use banks 0Fh, 08h, 09h and 0Bh respectively, whatever the page register holds.
- R5: Reads in C000h-DFFFh use bank bits [3:0] = {page[3], page[0], page[2], page[1]}.
- R6: The ROM address equals {bank[3:0], cpuAddr[12:0]}.
- R7: romEnable is high only while rdEn is high and the address is 6000h or above. Reads below 6000h and writes anywhere leave it low.
- R8: A decoded timer write with data bit 0 = 1 starts the count. irqN goes low on the 4096th rising clock edge after the edge that captured the write.
- R9: Once irqN is low it stays low and the count holds, with no wrap, until the timer is turned off.
- R10: A decoded timer write with data bit 0 = 0 stops the timer, clears the count to zero and returns irqN high on the capturing edge.
- R11: Writing 1 to the timer switch while the timer already runs does not restart or disturb the count.
- R12: A synchronous reset turns the timer off, clears the count and leaves irqN high.
- R13: Writes that fail the R1 decode change neither the page register nor the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock (M2); registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the timer |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| wrEn | input | 1 | CPU write strobe for the current bus cycle |
| rdEn | input | 1 | CPU read strobe for the current bus cycle |
| romAddr | output | 17 | ROM address, bank number over the 13-bit offset |
| romEnable | output | 1 | ROM select, active high |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The hardest condition to reach from the ports is a second write of 1 to the timer while it is already counting. This write must not restart the count, and its effect only shows 4096 cycles later as the exact position of the falling interrupt edge. The stimulus starts the timer and counts bus cycles at the falling clock edge. Partway through the run it injects the extra write in the middle of the count, then measures the distance to the edge and expects it to be unchanged. The same cycle-counting loop pins the interrupt to the exact edge. Long idle waits show that page writes, reset and mis-decoded timer writes never start the timer.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;

  // Strobes handed from the decode/control side to the datapath.
  typedef struct packed {
    logic pageLoad;   // capture the page number this cycle
    logic cntClear;   // zero the interval counter
    logic cntStep;    // advance the interval counter
  } mapper_strobe_t;

endpackage

// File: rtl/cart_mapper_ctrl.sv
module cart_mapper_ctrl
  import cart_mapper_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] DEC_MASK  = 16'hE060,
  parameter logic [15:0] DEC_VALUE = 16'h4020,
  parameter int          SEL_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wrEn,
  input  logic              timerBit,
  output mapper_strobe_t    strobes
);

  localparam logic [ADDR_W-1:0] MASK  = ADDR_W'(DEC_MASK);
  localparam logic [ADDR_W-1:0] VALUE = ADDR_W'(DEC_VALUE);

  logic regionHit;
  logic pageHit;
  logic timerHit;
  logic timerOn;

  // Sparse decode: only the masked bits take part, bit SEL_BIT picks the target.
  always_comb begin
    regionHit = wrEn && ((cpuAddr & MASK) == VALUE);
    pageHit   = regionHit && !cpuAddr[SEL_BIT];
    timerHit  = regionHit &&  cpuAddr[SEL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timerOn <= 1'b0;
    end else if (timerHit) begin
      timerOn <= timerBit;
    end
  end

  always_comb begin
    strobes.pageLoad = pageHit;
    strobes.cntClear = rst || (timerHit && !timerBit);
    strobes.cntStep  = timerOn && !strobes.cntClear;
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (timerHit && timerBit) |=> (strobes.cntStep || strobes.cntClear)) else $error("start lost"); // R8

  AST_PAGE_NOT_TIMER: assert property (@(posedge clk) disable iff (rst)
    (strobes.pageLoad && !timerOn) |=> !strobes.cntStep) else $error("page write ran timer"); // R2

endmodule

// File: rtl/cart_mapper_datapath.sv
module cart_mapper_datapath
  import cart_mapper_pkg::*;
#(
  parameter int             ADDR_W      = 16,
  parameter int             BANK_W      = 4,
  parameter int             OFFSET_W    = 13,
  parameter int             TIMER_LIMIT = 4096,
  parameter logic [3:0]     BANK_LOW    = 4'hF,
  parameter logic [3:0]     BANK_W4     = 4'h8,
  parameter logic [3:0]     BANK_W5     = 4'h9,
  parameter logic [3:0]     BANK_TOP    = 4'hB
) (
  input  logic                       clk,
  input  logic                       rst,
  input  mapper_strobe_t             strobes,
  input  logic [BANK_W-1:0]          pageIn,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic                       rdEn,
  output logic [BANK_W+OFFSET_W-1:0] romAddr,
  output logic                       romEnable,
  output logic                       irqN
);

  localparam int WIN_W = ADDR_W - OFFSET_W;
  localparam int CNT_W = $clog2(TIMER_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TIMER_LIMIT);
  localparam logic [WIN_W-1:0] WIN_FIRST = WIN_W'(3);

  logic [BANK_W-1:0] pageReg;
  logic [BANK_W-1:0] pagePerm;
  logic [BANK_W-1:0] bankSel;
  logic [WIN_W-1:0]  window;
  logic [CNT_W-1:0]  cnt;
  logic              cntDone;

  // Page register, no reset: power-up content is undefined on the real board.
  always_ff @(posedge clk) begin
    if (strobes.pageLoad) begin
      pageReg <= pageIn;
    end
  end

  // Bank bits [3:0] come from page bits 3,0,2,1.
  always_comb begin
    pagePerm = {pageReg[3], pageReg[0], pageReg[2], pageReg[1]};
  end

  always_comb begin
    window    = cpuAddr[ADDR_W-1:OFFSET_W];
    romEnable = rdEn && (window >= WIN_FIRST);
    unique case (window)
      3'd3:    bankSel = BANK_LOW;
      3'd4:    bankSel = BANK_W4;
      3'd5:    bankSel = BANK_W5;
      3'd6:    bankSel = pagePerm;
      3'd7:    bankSel = BANK_TOP;
      default: bankSel = '0;
    endcase
    romAddr = {bankSel, cpuAddr[OFFSET_W-1:0]};
  end

  // Interval counter: saturates at the limit so the request never re-fires.
  always_comb begin
    cntDone = (cnt == CNT_END);
  end

  always_ff @(posedge clk) begin
    if (strobes.cntClear) begin
      cnt <= '0;
    end else if (strobes.cntStep && !cntDone) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    irqN = !cntDone;
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.pageLoad |=> $stable(pageReg)) else $error("page changed"); // R13

  AST_CLEAR_RESULT: assert property (@(posedge clk)
    strobes.cntClear |=> (cnt == '0) && irqN) else $error("clear failed"); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_END) else $error("count past limit"); // R9

  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (!irqN && !strobes.cntClear) |=> !irqN) else $error("irq dropped"); // R9

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (strobes.cntStep && irqN) |=> (cnt == $past(cnt) + 1'b1)) else $error("no step"); // R8

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_mapper_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int BANK_W      = 4,
  parameter int OFFSET_W    = 13,
  parameter int TIMER_LIMIT = 4096
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [DATA_W-1:0]          cpuData,
  input  logic                       wrEn,
  input  logic                       rdEn,
  output logic [BANK_W+OFFSET_W-1:0] romAddr,
  output logic                       romEnable,
  output logic                       irqN
);

  mapper_strobe_t strobes;
  logic           unusedDataBits;

  assign unusedDataBits = ^cpuData[DATA_W-1:BANK_W];

  cart_mapper_ctrl #(
    .ADDR_W   (ADDR_W),
    .DEC_MASK (16'hE060),
    .DEC_VALUE(16'h4020),
    .SEL_BIT  (8)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cpuAddr (cpuAddr),
    .wrEn    (wrEn),
    .timerBit(cpuData[0]),
    .strobes (strobes)
  );

  cart_mapper_datapath #(
    .ADDR_W     (ADDR_W),
    .BANK_W     (BANK_W),
    .OFFSET_W   (OFFSET_W),
    .TIMER_LIMIT(TIMER_LIMIT)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .pageIn   (cpuData[BANK_W-1:0]),
    .cpuAddr  (cpuAddr),
    .rdEn     (rdEn),
    .romAddr  (romAddr),
    .romEnable(romEnable),
    .irqN     (irqN)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> irqN) else $error("irq after reset"); // R12

  AST_WRITE_NO_ROM: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !rdEn) |-> !romEnable) else $error("rom on write"); // R7

endmodule

// File: tb/test_cart_bank_mapper.sv
module test_cart_bank_mapper;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [16:0] romAddr;
  logic        romEnable;
  logic        irqN;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cart_bank_mapper i_cart_bank_mapper (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .wrEn(wrEn), .rdEn(rdEn), .romAddr(romAddr), .romEnable(romEnable), .irqN(irqN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    cpuAddr = a; wrEn = 1'b0; rdEn = 1'b1;
    #1;
  endtask

  function automatic logic [16:0] expAddr(input logic [3:0] bank, input logic [15:0] a);
    return {bank, a[12:0]};
  endfunction

  function automatic logic [3:0] permBank(input logic [3:0] p);
    return {p[3], p[0], p[2], p[1]};
  endfunction

  // Counts falling edges after a start until irqN drops; optional repeat start.
  task automatic runTimer(input int rewriteAt, output int n);
    n = 0;
    for (int i = 0; i < LIMIT + 200; i++) begin
      @(negedge clk);
      n++;
      if (n == rewriteAt) begin
        cpuAddr = 16'h4120; cpuData = 8'h01; wrEn = 1'b1;
      end else begin
        wrEn = 1'b0;
      end
      if (irqN == 1'b0) break;
    end
    wrEn = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R12 irq after reset", irqN, 1'b1);
    check("R7 rom idle after reset", romEnable, 1'b0);
  endtask

  task automatic t_fixed_windows();
    wr(16'h4020, 8'h05);
    rd(16'h6ABC); check("R4 window 6000", romAddr, expAddr(4'hF, 16'h6ABC));
    rd(16'h8001); check("R4 window 8000", romAddr, expAddr(4'h8, 16'h8001));
    rd(16'hBFFF); check("R4 window A000", romAddr, expAddr(4'h9, 16'hBFFF));
    rd(16'hE123); check("R4 window E000", romAddr, expAddr(4'hB, 16'hE123));
    wr(16'h4020, 8'h0E);
    rd(16'hFFFF); check("R4 window E000 page change", romAddr, expAddr(4'hB, 16'hFFFF));
    rd(16'h7000); check("R6 offset kept", romAddr, 17'h1F000);
  endtask

  task automatic t_page_perm();
    for (int p = 0; p < 16; p++) begin
      wr(16'h4020, 8'(p));
      rd(16'hC000 | 16'(p * 37));
      check($sformatf("R5 page %0d", p), romAddr, expAddr(permBank(4'(p)), 16'hC000 | 16'(p * 37)));
    end
    wr(16'h4020, 8'hFA);
    rd(16'hC123);
    check("R3 upper data bits dropped", romAddr, 17'h12123);
  endtask

  task automatic t_decode();
    wr(16'h4020, 8'h05);
    wr(16'h6020, 8'h0A);
    wr(16'h4060, 8'h0A);
    wr(16'h4000, 8'h0A);
    wr(16'hC020, 8'h0A);
    rd(16'hC000);
    check("R13 bad decode ignored", romAddr, expAddr(permBank(4'h5), 16'hC000));
    wr(16'h5EBF, 8'h0A);
    rd(16'hC000);
    check("R1 mirror 5EBF", romAddr, expAddr(permBank(4'hA), 16'hC000));
  endtask

  task automatic t_rom_enable();
    rd(16'h5000); check("R7 read below 6000", romEnable, 1'b0);
    rd(16'h6000); check("R7 read at 6000", romEnable, 1'b1);
    rd(16'hFFFF); check("R7 read at FFFF", romEnable, 1'b1);
    @(negedge clk);
    cpuAddr = 16'h8000; rdEn = 1'b0; wrEn = 1'b1; #1;
    check("R7 write no enable", romEnable, 1'b0);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_timer_basic();
    int n;
    wr(16'h4120, 8'h01);
    runTimer(0, n);
    check("R8 irq cycle", n, LIMIT);
    repeat (100) @(negedge clk);
    check("R9 irq held", irqN, 1'b0);
    wr(16'h4120, 8'h00);
    check("R10 irq released", irqN, 1'b1);
    wr(16'h5DA0, 8'hFF);
    runTimer(0, n);
    check("R2 timer mirror full interval", n, LIMIT);
    wr(16'h4120, 8'h02);
    check("R10 bit0 zero stops", irqN, 1'b1);
  endtask

  task automatic t_timer_rewrite();
    int n;
    wr(16'h4120, 8'h01);
    runTimer(2000, n);
    check("R11 repeat start no restart", n, LIMIT);
    wr(16'h4120, 8'h00);
  endtask

  task automatic t_timer_reset();
    wr(16'h4120, 8'h01);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset clears", irqN, 1'b1);
    repeat (LIMIT + 100) @(negedge clk);
    check("R12 timer stays off", irqN, 1'b1);
  endtask

  task automatic t_no_false_start();
    wr(16'h4020, 8'h01);
    wr(16'h4160, 8'h01);
    wr(16'h6120, 8'h01);
    repeat (LIMIT + 100) @(negedge clk);
    check("R2 page write no timer", irqN, 1'b1);
    rd(16'hC000);
    check("R13 mis-decoded writes ignored", romAddr, expAddr(permBank(4'h1), 16'hC000));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed_windows();
    t_page_perm();
    t_decode();
    t_rom_enable();
    t_timer_basic();
    t_timer_rewrite();
    t_timer_reset();
    t_no_false_start();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule